// File: doc/BRIEF.md
# Multiply-Divide Unit with Shared Wide Accumulator

This block does integer multiply and divide next to a processor's main datapath. It owns one accumulator that is twice the operand width. The upper half is called HI and the lower half LO. Several operations write it: a full-width multiply, multiply-add and multiply-subtract, each in a signed and an unsigned form. Signed and unsigned division also write it, placing the quotient in LO and the remainder in HI.

A separate three-operand multiply returns only the low half of the signed product on its own output. It leaves the accumulator alone. Each half of the accumulator can be loaded from an operand on its own, and either half can be read through a read port.

Multiplies complete in the clock edge that accepts them. Division runs a restoring divider, one quotient bit per cycle. While it runs, `busy` is high, new commands are refused and reads of HI or LO are held off.

Top module: `mul_div_unit`

## Requirements
- R1: Operation codes 0 (signed) and 1 (unsigned) write the full double-width product of `opA` and `opB` into {HI,LO` }` at the edge that accepts `start`. They do not raise `busy`.
- R2: Codes 2 (signed) and 3 (unsigned) add the double-width product to {HI,LO}, modulo 2^(2·WIDTH).
- R3: Codes 4 (signed) and 5 (unsigned) subtract the double-width product from {HI,LO}, modulo 2^(2·WIDTH).
- R4: Codes 6 (signed) and 7 (unsigned) divide `opA` by `opB`. The quotient goes to LO and the remainder to HI. Signed division truncates toward zero, and the remainder takes the sign of the dividend. With a zero divisor, HI and LO are undefined.
- R5: Code 8 puts the low WIDTH bits of the signed product on `mulOut`, with `mulValid` high for exactly the one cycle after the accepting edge. HI and LO are unchanged.
- R6: Code 9 loads HI from `opA` and code 10 loads LO from `opA`. In each case the other half is unchanged.
- R7: A divide raises `busy` for exactly WIDTH cycles after the accepting edge. The result is readable in the first cycle with `busy` low.
- R8: `start` is ignored while `busy` is high. Codes 11 to 15 have no effect on HI, LO or `mulValid`.
- R9: `rdAck` is high only when `rdReq` is high and `busy` is low. `rdData` is HI when `rdSelHi` is 1 and LO when it is 0.
- R10: A signed divide of the most negative value by -1 gives quotient equal to the most negative value and remainder 0.
- R11: After reset, HI and LO are zero and `busy` and `mulValid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Issue the command in `op` |
| op | input | 4 | Operation code |
| opA | input | WIDTH | First operand / dividend / load value |
| opB | input | WIDTH | Second operand / divisor |
| busy | output | 1 | Divide in progress |
| rdReq | input | 1 | Request a read of HI or LO |
| rdSelHi | input | 1 | 1 selects HI, 0 selects LO |
| rdAck | output | 1 | Read data valid this cycle |
| rdData | output | WIDTH | Selected accumulator half |
| mulOut | output | WIDTH | Low half of the three-operand product |
| mulValid | output | 1 | `mulOut` updated |

## Verification
The bench builds the unit with WIDTH = 4, so the accumulator is 8 bits wide. At that width every pair of operands can be swept for every multiply, accumulate, subtract and divide code. Expected values come from integer arithmetic in the bench. The sweep reaches each sign combination, the wrap of the accumulator in both directions, and the most-negative-by-minus-one quotient. Divide sweeps also count `busy` cycles for every operand pair and probe the read stall.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

  typedef enum logic [3:0] {
    OP_MULT   = 4'd0,
    OP_MULTU  = 4'd1,
    OP_MADD   = 4'd2,
    OP_MADDU  = 4'd3,
    OP_MSUB   = 4'd4,
    OP_MSUBU  = 4'd5,
    OP_DIV    = 4'd6,
    OP_DIVU   = 4'd7,
    OP_MUL3   = 4'd8,
    OP_SETHI  = 4'd9,
    OP_SETLO  = 4'd10
  } mduOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic mulWr;     // write accumulator from the multiply path
    logic mulAcc;    // add product to accumulator
    logic mulSub;    // subtract product from accumulator
    logic isSigned;  // operands are two's complement
    logic mul3;      // three-operand multiply, result to mulOut
    logic setHi;     // load HI from opA
    logic setLo;     // load LO from opA
    logic divLoad;   // capture divide operands
    logic divStep;   // one restoring iteration
    logic divFinish; // last iteration, write HI/LO
  } mduCtrl_t;

endpackage

// File: rtl/mdu_ctrl.sv
module mdu_ctrl
  import mdu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [3:0] op,
  output mduCtrl_t   ctl,
  output logic       busy
);

  localparam int CNT_W = (WIDTH > 2) ? $clog2(WIDTH) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WIDTH - 1);

  logic             busyQ;
  logic [CNT_W-1:0] iterCnt;
  logic             accept;

  assign accept = start & ~busyQ;
  assign busy   = busyQ;

  always_comb begin
    ctl = '0;
    if (accept) begin
      case (mduOp_e'(op))
        OP_MULT:  begin ctl.mulWr = 1'b1; ctl.isSigned = 1'b1; end
        OP_MULTU: begin ctl.mulWr = 1'b1; end
        OP_MADD:  begin ctl.mulWr = 1'b1; ctl.mulAcc = 1'b1; ctl.isSigned = 1'b1; end
        OP_MADDU: begin ctl.mulWr = 1'b1; ctl.mulAcc = 1'b1; end
        OP_MSUB:  begin ctl.mulWr = 1'b1; ctl.mulSub = 1'b1; ctl.isSigned = 1'b1; end
        OP_MSUBU: begin ctl.mulWr = 1'b1; ctl.mulSub = 1'b1; end
        OP_DIV:   begin ctl.divLoad = 1'b1; ctl.isSigned = 1'b1; end
        OP_DIVU:  begin ctl.divLoad = 1'b1; end
        OP_MUL3:  begin ctl.mul3 = 1'b1; ctl.isSigned = 1'b1; end
        OP_SETHI: begin ctl.setHi = 1'b1; end
        OP_SETLO: begin ctl.setLo = 1'b1; end
        default:  ;
      endcase
    end
    ctl.divStep   = busyQ;
    ctl.divFinish = busyQ && (iterCnt == LAST_CNT);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ   <= 1'b0;
      iterCnt <= '0;
    end else if (ctl.divLoad) begin
      busyQ   <= 1'b1;
      iterCnt <= '0;
    end else if (busyQ) begin
      if (ctl.divFinish) busyQ <= 1'b0;
      else               iterCnt <= iterCnt + 1'b1;
    end
  end

  AST_BUSY_FROM_DIV: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busyQ) |-> $past(start && (op == OP_DIV || op == OP_DIVU))); // R7

  AST_DIV_LENGTH: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busyQ) |-> $past(iterCnt) == LAST_CNT); // R7

  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.mulWr, ctl.mul3, ctl.setHi, ctl.setLo, ctl.divLoad})); // R8

  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    busyQ |-> !(ctl.mulWr || ctl.mul3 || ctl.setHi || ctl.setLo || ctl.divLoad)); // R8

endmodule

// File: rtl/mdu_divider.sv
module mdu_divider #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             load,
  input  logic             step,
  input  logic             isSigned,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic [WIDTH-1:0] quotient,
  output logic [WIDTH-1:0] remainder
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] remQ, quoQ, dvsQ;
  logic             negQuo, negRem;
  logic [WIDTH-1:0] magA, magB;
  logic [WIDTH:0]   shifted, diff;
  logic             qBit;
  logic [WIDTH-1:0] remNext, quoNext;

  assign magA = (isSigned && dividend[MSB]) ? -dividend : dividend;
  assign magB = (isSigned && divisor[MSB])  ? -divisor  : divisor;

  assign shifted = {remQ, quoQ[MSB]};
  assign diff    = shifted - {1'b0, dvsQ};
  assign qBit    = ~diff[WIDTH];
  assign remNext = qBit ? diff[WIDTH-1:0] : shifted[WIDTH-1:0];
  assign quoNext = {quoQ[MSB-1:0], qBit};

  // sign fixup of the value that the final step produces
  assign quotient  = negQuo ? -quoNext : quoNext;
  assign remainder = negRem ? -remNext : remNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remQ   <= '0;
      quoQ   <= '0;
      dvsQ   <= '0;
      negQuo <= 1'b0;
      negRem <= 1'b0;
    end else if (load) begin
      remQ   <= '0;
      quoQ   <= magA;
      dvsQ   <= magB;
      negQuo <= isSigned & (dividend[MSB] ^ divisor[MSB]);
      negRem <= isSigned & dividend[MSB];
    end else if (step) begin
      remQ <= remNext;
      quoQ <= quoNext;
    end
  end

  AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rstN)
    (step && dvsQ != '0) |=> remQ < dvsQ); // R4

endmodule

// File: rtl/mdu_datapath.sv
module mdu_datapath
  import mdu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  mduCtrl_t         ctl,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH-1:0] hi,
  output logic [WIDTH-1:0] lo,
  output logic [WIDTH-1:0] mulOut,
  output logic             mulValid
);

  localparam int ACC_W = 2 * WIDTH;
  localparam int MSB   = WIDTH - 1;

  logic [ACC_W-1:0] accQ, accNext, aExt, bExt, product;
  logic [WIDTH-1:0] divQuo, divRem;

  assign aExt    = {{WIDTH{ctl.isSigned & opA[MSB]}}, opA};
  assign bExt    = {{WIDTH{ctl.isSigned & opB[MSB]}}, opB};
  assign product = aExt * bExt;

  always_comb begin
    if (ctl.mulAcc)      accNext = accQ + product;
    else if (ctl.mulSub) accNext = accQ - product;
    else                 accNext = product;
  end

  mdu_divider #(.WIDTH(WIDTH)) uDiv (
    .clk      (clk),
    .rstN     (rstN),
    .load     (ctl.divLoad),
    .step     (ctl.divStep),
    .isSigned (ctl.isSigned),
    .dividend (opA),
    .divisor  (opB),
    .quotient (divQuo),
    .remainder(divRem)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accQ <= '0;
    end else if (ctl.mulWr) begin
      accQ <= accNext;
    end else if (ctl.setHi) begin
      accQ[ACC_W-1:WIDTH] <= opA;
    end else if (ctl.setLo) begin
      accQ[WIDTH-1:0] <= opA;
    end else if (ctl.divFinish) begin
      accQ <= {divRem, divQuo};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mulOut   <= '0;
      mulValid <= 1'b0;
    end else begin
      mulValid <= ctl.mul3;
      if (ctl.mul3) mulOut <= product[WIDTH-1:0];
    end
  end

  assign hi = accQ[ACC_W-1:WIDTH];
  assign lo = accQ[WIDTH-1:0];

  AST_MUL3_KEEPS_ACC: assert property (@(posedge clk) disable iff (!rstN)
    ctl.mul3 |=> $stable(accQ)); // R5

  AST_SETHI_KEEPS_LO: assert property (@(posedge clk) disable iff (!rstN)
    ctl.setHi |=> $stable(accQ[WIDTH-1:0])); // R6

  AST_SETLO_KEEPS_HI: assert property (@(posedge clk) disable iff (!rstN)
    ctl.setLo |=> $stable(accQ[ACC_W-1:WIDTH])); // R6

  AST_ACC_FROZEN_DIV: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.divStep && !ctl.divFinish) |=> $stable(accQ)); // R8

endmodule

// File: rtl/mul_div_unit.sv
module mul_div_unit
  import mdu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [3:0]       op,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic             busy,
  input  logic             rdReq,
  input  logic             rdSelHi,
  output logic             rdAck,
  output logic [WIDTH-1:0] rdData,
  output logic [WIDTH-1:0] mulOut,
  output logic             mulValid
);

  mduCtrl_t         ctl;
  logic [WIDTH-1:0] hi, lo;

  mdu_ctrl #(.WIDTH(WIDTH)) uCtrl (
    .clk  (clk),
    .rstN (rstN),
    .start(start),
    .op   (op),
    .ctl  (ctl),
    .busy (busy)
  );

  mdu_datapath #(.WIDTH(WIDTH)) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .opA     (opA),
    .opB     (opB),
    .hi      (hi),
    .lo      (lo),
    .mulOut  (mulOut),
    .mulValid(mulValid)
  );

  assign rdAck  = rdReq & ~busy;
  assign rdData = rdSelHi ? hi : lo;

  AST_READ_STALL: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && ctl.divStep) |-> !rdAck); // R9

endmodule

// File: tb/sim_mul_div_unit.sv
`timescale 1ns/1ps
module sim_mul_div_unit;

  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic [3:0]   op = '0;
  logic [W-1:0] opA = '0, opB = '0;
  logic         busy;
  logic         rdReq = 1'b0, rdSelHi = 1'b0;
  logic         rdAck;
  logic [W-1:0] rdData, mulOut;
  logic         mulValid;

  int tests = 0;
  int fails = 0;
  logic [2*W-1:0] model = '0;

  always #4 clk = ~clk;

  mul_div_unit #(.WIDTH(W)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .op(op), .opA(opA), .opB(opB),
    .busy(busy), .rdReq(rdReq), .rdSelHi(rdSelHi), .rdAck(rdAck),
    .rdData(rdData), .mulOut(mulOut), .mulValid(mulValid)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int sx(input logic [W-1:0] v);
    return v[W-1] ? int'(v) - (1 << W) : int'(v);
  endfunction

  function automatic logic [2*W-1:0] prodS(input logic [W-1:0] a, input logic [W-1:0] b);
    return (2*W)'(sx(a) * sx(b));
  endfunction

  function automatic logic [2*W-1:0] prodU(input logic [W-1:0] a, input logic [W-1:0] b);
    return (2*W)'(int'(a) * int'(b));
  endfunction

  // drive one command; returns at the negedge after the accepting edge
  task automatic issue(input logic [3:0] c, input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk);
    start = 1'b1; op = c; opA = a; opB = b;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic readAcc(output logic [2*W-1:0] v);
    rdReq = 1'b1; rdSelHi = 1'b1;
    #1 v[2*W-1:W] = rdData;
    rdSelHi = 1'b0;
    #1 v[W-1:0] = rdData;
    rdReq = 1'b0;
  endtask

  task automatic waitIdle(output int n);
    n = 0;
    while (busy) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [2*W-1:0] got;
    logic [2*W-1:0] exp;
    int n;

    repeat (3) @(negedge clk);
    readAcc(got);
    check("R11 acc after reset", 32'(got), 32'h0);
    check("R11 busy after reset", 32'(busy), 32'h0);
    check("R11 mulValid after reset", 32'(mulValid), 32'h0);
    rstN = 1'b1;

    // R1: plain multiply, signed then unsigned
    for (int s = 0; s < 2; s++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++) begin
          issue(4'(s), W'(a), W'(b));
          check("R1 no busy on multiply", 32'(busy), 32'h0);
          readAcc(got);
          model = (s == 0) ? prodS(W'(a), W'(b)) : prodU(W'(a), W'(b));
          check(s == 0 ? "R1 signed product" : "R1 unsigned product", 32'(got), 32'(model));
        end

    // R2 / R3: running accumulate and subtract
    for (int c = 2; c < 6; c++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++) begin
          issue(4'(c), W'(a), W'(b));
          exp = (c[0] == 1'b0) ? prodS(W'(a), W'(b)) : prodU(W'(a), W'(b));
          model = (c < 4) ? model + exp : model - exp;
          readAcc(got);
          check(c < 4 ? "R2 multiply-add" : "R3 multiply-subtract", 32'(got), 32'(model));
        end

    // R6 / R9: half loads and read select
    issue(4'd9, 4'hA, 4'h0);
    model[2*W-1:W] = 4'hA;
    readAcc(got);
    check("R6 load HI keeps LO", 32'(got), 32'(model));
    issue(4'd10, 4'h5, 4'h0);
    model[W-1:0] = 4'h5;
    rdReq = 1'b1; rdSelHi = 1'b1;
    #1 check("R9 read HI select", 32'(rdData), 32'hA);
    check("R9 ack when idle", 32'(rdAck), 32'h1);
    rdSelHi = 1'b0;
    #1 check("R9 read LO select", 32'(rdData), 32'h5);
    check("R6 load LO", 32'(rdData), 32'h5);
    rdReq = 1'b0;

    // R5: three-operand multiply
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++) begin
        issue(4'd8, W'(a), W'(b));
        check("R5 mulValid pulse", 32'(mulValid), 32'h1);
        check("R5 low product", 32'(mulOut), 32'(prodS(W'(a), W'(b)) & 8'h0F));
        if (a == 15 && b == 15) begin
          @(negedge clk);
          check("R5 mulValid one cycle", 32'(mulValid), 32'h0);
        end
      end
    readAcc(got);
    check("R5 acc untouched", 32'(got), 32'(model));

    // R4 / R7 / R9: divide sweeps
    for (int s = 0; s < 2; s++)
      for (int a = 0; a < 16; a++)
        for (int b = 1; b < 16; b++) begin
          issue(4'(6 + s), W'(a), W'(b));
          rdReq = 1'b1;
          #1 check("R9 read stalls while busy", 32'(rdAck), 32'h0);
          rdReq = 1'b0;
          waitIdle(n);
          check("R7 busy length", 32'(n), 32'(W));
          if (s == 0)
            exp = {W'(sx(W'(a)) % sx(W'(b))), W'(sx(W'(a)) / sx(W'(b)))};
          else
            exp = {W'(a % b), W'(a / b)};
          readAcc(got);
          check(s == 0 ? "R4 signed divide" : "R4 unsigned divide", 32'(got), 32'(exp));
        end

    // R10: most negative by minus one
    issue(4'd6, 4'h8, 4'hF);
    waitIdle(n);
    readAcc(got);
    check("R10 overflow divide", 32'(got), 32'h08);
    model = got;

    // R8: start ignored while busy
    issue(4'd6, 4'h7, 4'h2);
    start = 1'b1; op = 4'd0; opA = 4'h3; opB = 4'h3;
    @(negedge clk);
    start = 1'b0;
    waitIdle(n);
    readAcc(got);
    check("R8 start ignored while busy", 32'(got), 32'h13);
    model = got;

    // R8: undefined codes have no effect
    for (int c = 11; c < 16; c++) begin
      issue(4'(c), 4'h6, 4'h7);
      check("R8 undefined code no busy", 32'(busy), 32'h0);
      check("R8 undefined code no mulValid", 32'(mulValid), 32'h0);
      readAcc(got);
      check("R8 undefined code keeps acc", 32'(got), 32'(model));
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule